// File: doc/BRIEF.md
# Load Writeback and Reservation Unit

This unit sits between a core's load pipeline and its register file. On the request side it decides at once whether an address is misaligned for the chosen access size. A platform strap can switch that check off when the memory system handles unaligned accesses itself. On the response side it takes the raw bytes returned by memory and widens them to a full register. The widening is zero-fill or sign-fill, chosen per access. The unit then issues a register write. If memory reported a fault, it raises a trap that carries the faulting address instead.

Every response retires one cycle later with a success or failure status. A load-reserved response that completes without a fault also records the address it used as the current reservation. A separate cancel input clears that reservation, for example when a store-conditional resolves.

Top module: `load_writeback_unit`

## Requirements
- R1: When the width code is 2'b00 (byte), `misaligned` is never asserted.
- R2: With the platform enable low and `req_valid` high, `misaligned` is a combinational function of the request. Width 2'b01 (half) flags when address bit 0 is 1. Width 2'b10 (word) flags when either of bits 1:0 is 1. Width 2'b11 (double) flags when any of bits 2:0 is 1.
- R3: While `plat_misaligned_ok` is high, `misaligned` stays low for every width and address.
- R4: With `rsp_unsigned` high, the low 1, 2, 4 or 8 bytes of `rsp_data` (width 2'b00..2'b11) appear in `wb_data`. All bits above them are zero.
- R5: With `rsp_unsigned` low, the bits above the selected bytes are copies of the top bit of those bytes.
- R6: A response without a fault and with a non-zero `rsp_rd` has an effect on the edge after it is accepted. That edge drives `wb_valid` high, `wb_rd`=`rsp_rd`, `retire_valid` high and `retire_ok` high.
- R7: A response with `rsp_fault` high has an effect on the edge after it is accepted. `wb_valid` stays low, `trap_valid` goes high, `trap_addr`=`rsp_addr` and `trap_cause`=`rsp_cause`. `retire_valid` goes high and `retire_ok` stays low.
- R8: A fault-free response with `rsp_rd`=0 leaves `wb_valid` low but still retires with `retire_ok` high.
- R9: A fault-free response with `rsp_reserve` high sets `resv_valid` and loads `resv_addr` with `rsp_addr`. This happens on the same edge that raises the writeback.
- R10: A faulting response with `rsp_reserve` high leaves `resv_valid` and `resv_addr` unchanged.
- R11: `resv_cancel` clears `resv_valid` on the next edge. It wins over a reservation set in the same cycle.
- R12: Reset clears all valid outputs and the reservation. `wb_valid`, `trap_valid` and `retire_valid` are high for exactly one cycle per accepted response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request address is present |
| req_addr | input | XLEN | Virtual address of the request |
| req_width | input | 2 | Access size code of the request |
| plat_misaligned_ok | input | 1 | Platform handles unaligned accesses |
| misaligned | output | 1 | Request address is misaligned |
| rsp_valid | input | 1 | Memory response present |
| rsp_addr | input | XLEN | Virtual address of the response |
| rsp_width | input | 2 | Access size code of the response |
| rsp_unsigned | input | 1 | Zero-fill instead of sign-fill |
| rsp_reserve | input | 1 | Response belongs to a load-reserved |
| rsp_rd | input | 5 | Destination register index |
| rsp_data | input | XLEN | Raw returned bytes, right-aligned |
| rsp_fault | input | 1 | Memory reported an exception |
| rsp_cause | input | CAUSE_W | Exception cause code |
| resv_cancel | input | 1 | Drop the current reservation |
| wb_valid | output | 1 | Register write strobe |
| wb_rd | output | 5 | Register write index |
| wb_data | output | XLEN | Register write value |
| trap_valid | output | 1 | Exception raised |
| trap_addr | output | XLEN | Address that faulted |
| trap_cause | output | CAUSE_W | Cause of the exception |
| retire_valid | output | 1 | Response retired |
| retire_ok | output | 1 | Retirement succeeded |
| resv_valid | output | 1 | Reservation held |
| resv_addr | output | XLEN | Reserved address |

## Verification
A reservation set by a successful load-reserved and a cancel can land on the same edge. The bench provokes this by first establishing a reservation, then raising `resv_cancel` during a fresh fault-free reserved response to a new address. It judges the outcome at the ports: the writeback for that response must still appear, and `resv_valid` must read low on that same cycle.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

    typedef enum logic [1:0] {
        ACC_B = 2'b00,
        ACC_H = 2'b01,
        ACC_W = 2'b10,
        ACC_D = 2'b11
    } acc_width_e;

    typedef struct packed {
        acc_width_e width;
        logic       is_unsigned;
        logic       reserve;
        logic [4:0] rd;
    } rsp_ctl_t;

    // Low address bits that must be zero for a naturally aligned access.
    function automatic logic [2:0] align_mask(acc_width_e w);
        case (w)
            ACC_H:   return 3'b001;
            ACC_W:   return 3'b011;
            ACC_D:   return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/lwb_align_check.sv
module lwb_align_check
    import lwb_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            valid,
    input  logic [XLEN-1:0] addr,
    input  acc_width_e      width,
    input  logic            plat_ok,
    output logic            misaligned
);
    logic [2:0] low_bits;

    assign low_bits   = addr[2:0];
    assign misaligned = valid && !plat_ok && (|(low_bits & align_mask(width)));

endmodule

// File: rtl/lwb_extend.sv
module lwb_extend
    import lwb_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] raw,
    input  acc_width_e      width,
    input  logic            is_unsigned,
    output logic [XLEN-1:0] value
);
    localparam int NSIZES = $clog2(XLEN / 8) + 1;

    logic [XLEN-1:0] cand [NSIZES];

    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        localparam int NB = 8 << g;
        logic fill;
        assign fill = is_unsigned ? 1'b0 : raw[NB-1];
        if (NB < XLEN) begin : g_pad
            assign cand[g] = {{(XLEN - NB){fill}}, raw[NB-1:0]};
        end else begin : g_full
            assign cand[g] = raw;
        end
    end

    always_comb begin
        if (int'(width) < NSIZES) value = cand[int'(width)];
        else                      value = cand[NSIZES-1];
    end

endmodule

// File: rtl/lwb_resv.sv
module lwb_resv #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set,
    input  logic [XLEN-1:0] set_addr,
    input  logic            cancel,
    output logic            held,
    output logic [XLEN-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
            addr <= '0;
        end else if (cancel) begin
            held <= 1'b0;
        end else if (set) begin
            held <= 1'b1;
            addr <= set_addr;
        end
    end

    // R11
    cancel_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cancel |=> !held);

    // R9
    set_only_on_request_chk: assert property (@(posedge clk) disable iff (rst)
        (!set && !held) |=> !held);

endmodule

// File: rtl/load_writeback_unit.sv
module load_writeback_unit
    import lwb_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [XLEN-1:0]    req_addr,
    input  logic [1:0]         req_width,
    input  logic               plat_misaligned_ok,
    output logic               misaligned,
    input  logic               rsp_valid,
    input  logic [XLEN-1:0]    rsp_addr,
    input  logic [1:0]         rsp_width,
    input  logic               rsp_unsigned,
    input  logic               rsp_reserve,
    input  logic [4:0]         rsp_rd,
    input  logic [XLEN-1:0]    rsp_data,
    input  logic               rsp_fault,
    input  logic [CAUSE_W-1:0] rsp_cause,
    input  logic               resv_cancel,
    output logic               wb_valid,
    output logic [4:0]         wb_rd,
    output logic [XLEN-1:0]    wb_data,
    output logic               trap_valid,
    output logic [XLEN-1:0]    trap_addr,
    output logic [CAUSE_W-1:0] trap_cause,
    output logic               retire_valid,
    output logic               retire_ok,
    output logic               resv_valid,
    output logic [XLEN-1:0]    resv_addr
);
    rsp_ctl_t        ctl;
    logic [XLEN-1:0] ext_value;
    logic            good;
    logic            resv_set;

    assign ctl.width       = acc_width_e'(rsp_width);
    assign ctl.is_unsigned = rsp_unsigned;
    assign ctl.reserve     = rsp_reserve;
    assign ctl.rd          = rsp_rd;

    assign good     = rsp_valid && !rsp_fault;
    assign resv_set = good && ctl.reserve;

    lwb_align_check #(.XLEN(XLEN)) u_align (
        .valid      (req_valid),
        .addr       (req_addr),
        .width      (acc_width_e'(req_width)),
        .plat_ok    (plat_misaligned_ok),
        .misaligned (misaligned)
    );

    lwb_extend #(.XLEN(XLEN)) u_extend (
        .raw         (rsp_data),
        .width       (ctl.width),
        .is_unsigned (ctl.is_unsigned),
        .value       (ext_value)
    );

    lwb_resv #(.XLEN(XLEN)) u_resv (
        .clk      (clk),
        .rst      (rst),
        .set      (resv_set),
        .set_addr (rsp_addr),
        .cancel   (resv_cancel),
        .held     (resv_valid),
        .addr     (resv_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid     <= 1'b0;
            wb_rd        <= '0;
            wb_data      <= '0;
            trap_valid   <= 1'b0;
            trap_addr    <= '0;
            trap_cause   <= '0;
            retire_valid <= 1'b0;
            retire_ok    <= 1'b0;
        end else begin
            wb_valid     <= good && (ctl.rd != 5'd0);
            trap_valid   <= rsp_valid && rsp_fault;
            retire_valid <= rsp_valid;
            retire_ok    <= good;
            if (good) begin
                wb_rd   <= ctl.rd;
                wb_data <= ext_value;
            end
            if (rsp_valid && rsp_fault) begin
                trap_addr  <= rsp_addr;
                trap_cause <= rsp_cause;
            end
        end
    end

    // R7
    no_write_on_trap_chk: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> (!wb_valid && !retire_ok));

    // R12
    retire_follows_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |=> (!retire_valid && !wb_valid && !trap_valid));

    // R3
    plat_override_chk: assert property (@(posedge clk) disable iff (rst)
        plat_misaligned_ok |-> !misaligned);

    // R1
    byte_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (req_width == 2'b00) |-> !misaligned);

    // R8
    x0_write_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault && rsp_rd == 5'd0) |=> (!wb_valid && retire_ok));

    // R10
    fault_keeps_resv_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault && !resv_cancel) |=> $stable(resv_addr));

endmodule

// File: tb/tb_load_writeback_unit.sv
module tb_load_writeback_unit;
    localparam int XLEN = 64;
    localparam int CW   = 5;

    logic            clk = 1'b0;
    logic            rst;
    logic            req_valid, plat_misaligned_ok, misaligned;
    logic [XLEN-1:0] req_addr;
    logic [1:0]      req_width;
    logic            rsp_valid, rsp_unsigned, rsp_reserve, rsp_fault, resv_cancel;
    logic [XLEN-1:0] rsp_addr, rsp_data;
    logic [1:0]      rsp_width;
    logic [4:0]      rsp_rd;
    logic [CW-1:0]   rsp_cause;
    logic            wb_valid, trap_valid, retire_valid, retire_ok, resv_valid;
    logic [4:0]      wb_rd;
    logic [XLEN-1:0] wb_data, trap_addr, resv_addr;
    logic [CW-1:0]   trap_cause;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    load_writeback_unit #(.XLEN(XLEN), .CAUSE_W(CW)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_width(req_width),
        .plat_misaligned_ok(plat_misaligned_ok), .misaligned(misaligned),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_width(rsp_width),
        .rsp_unsigned(rsp_unsigned), .rsp_reserve(rsp_reserve), .rsp_rd(rsp_rd),
        .rsp_data(rsp_data), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .resv_cancel(resv_cancel),
        .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data),
        .trap_valid(trap_valid), .trap_addr(trap_addr), .trap_cause(trap_cause),
        .retire_valid(retire_valid), .retire_ok(retire_ok),
        .resv_valid(resv_valid), .resv_addr(resv_addr)
    );

    typedef struct packed {
        logic [1:0]  w;
        logic        uns;
        logic [63:0] data;
        logic [63:0] exp;
    } vec_t;

    localparam logic [63:0] DA = 64'hFFEE_DDCC_BBAA_9988;
    localparam logic [63:0] DB = 64'h1234_5678_9ABC_7F42;

    localparam vec_t VECS [12] = '{
        '{2'b00, 1'b0, DA, 64'hFFFF_FFFF_FFFF_FF88},   // R5
        '{2'b00, 1'b1, DA, 64'h0000_0000_0000_0088},   // R4
        '{2'b01, 1'b0, DA, 64'hFFFF_FFFF_FFFF_9988},   // R5
        '{2'b01, 1'b1, DA, 64'h0000_0000_0000_9988},   // R4
        '{2'b10, 1'b0, DA, 64'hFFFF_FFFF_BBAA_9988},   // R5
        '{2'b10, 1'b1, DA, 64'h0000_0000_BBAA_9988},   // R4
        '{2'b11, 1'b0, DA, DA},                        // R5
        '{2'b11, 1'b1, DA, DA},                        // R4
        '{2'b00, 1'b0, DB, 64'h0000_0000_0000_0042},   // R5
        '{2'b01, 1'b0, DB, 64'h0000_0000_0000_7F42},   // R5
        '{2'b10, 1'b0, DB, 64'hFFFF_FFFF_9ABC_7F42},   // R5
        '{2'b10, 1'b1, DB, 64'h0000_0000_9ABC_7F42}    // R4
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_rsp();
        rsp_valid = 0; rsp_fault = 0; rsp_reserve = 0; rsp_unsigned = 0;
        rsp_rd = 0; rsp_width = 0; rsp_addr = 0; rsp_data = 0; rsp_cause = 0;
        resv_cancel = 0;
    endtask

    // Drive one response at a negedge; outputs are sampled at the next negedge.
    task automatic send(logic [63:0] addr, logic [1:0] w, logic uns, logic res,
                        logic [4:0] rd, logic [63:0] data, logic flt, logic [4:0] cause,
                        logic cancel);
        rsp_valid = 1; rsp_addr = addr; rsp_width = w; rsp_unsigned = uns;
        rsp_reserve = res; rsp_rd = rd; rsp_data = data; rsp_fault = flt;
        rsp_cause = cause; resv_cancel = cancel;
        @(negedge clk);
        idle_rsp();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; req_valid = 0; req_addr = 0; req_width = 0; plat_misaligned_ok = 0;
        idle_rsp();
        rsp_valid = 1; rsp_reserve = 1; rsp_rd = 5'd3;
        repeat (3) @(negedge clk);
        idle_rsp();
        // R12 reset state
        check("R12 reset wb_valid", {63'd0, wb_valid}, 64'd0);
        check("R12 reset retire_valid", {63'd0, retire_valid}, 64'd0);
        check("R12 reset trap_valid", {63'd0, trap_valid}, 64'd0);
        check("R12 reset resv_valid", {63'd0, resv_valid}, 64'd0);
        rst = 0;
        @(negedge clk);

        // R4 R5 R6 extension table
        for (int i = 0; i < 12; i++) begin
            send(64'h100 + i, VECS[i].w, VECS[i].uns, 1'b0, 5'd7, VECS[i].data, 1'b0, 5'd0, 1'b0);
            check($sformatf("R4/R5 vec%0d wb_data", i), wb_data, VECS[i].exp);
            check("R6 wb_valid", {63'd0, wb_valid}, 64'd1);
            check("R6 wb_rd", {59'd0, wb_rd}, 64'd7);
            check("R6 retire_ok", {62'd0, retire_valid, retire_ok}, 64'd3);
        end
        @(negedge clk);
        // R12 single-cycle pulses
        check("R12 pulse ends", {61'd0, wb_valid, retire_valid, trap_valid}, 64'd0);

        // R8 x0 destination
        send(64'h200, 2'b11, 1'b0, 1'b0, 5'd0, DA, 1'b0, 5'd0, 1'b0);
        check("R8 no write", {63'd0, wb_valid}, 64'd0);
        check("R8 retire ok", {62'd0, retire_valid, retire_ok}, 64'd3);

        // R7 fault
        send(64'hDEAD_0004, 2'b10, 1'b0, 1'b0, 5'd9, DA, 1'b1, 5'd13, 1'b0);
        check("R7 no write", {63'd0, wb_valid}, 64'd0);
        check("R7 trap_valid", {63'd0, trap_valid}, 64'd1);
        check("R7 trap_addr", trap_addr, 64'hDEAD_0004);
        check("R7 trap_cause", {59'd0, trap_cause}, 64'd13);
        check("R7 retire fail", {62'd0, retire_valid, retire_ok}, 64'd2);

        // R9 reservation set with write
        send(64'h8000_1000, 2'b10, 1'b0, 1'b1, 5'd4, DB, 1'b0, 5'd0, 1'b0);
        check("R9 wb_valid", {63'd0, wb_valid}, 64'd1);
        check("R9 resv_valid", {63'd0, resv_valid}, 64'd1);
        check("R9 resv_addr", resv_addr, 64'h8000_1000);

        // R10 faulting reserved load leaves reservation alone
        send(64'h8000_2000, 2'b10, 1'b0, 1'b1, 5'd4, DB, 1'b1, 5'd5, 1'b0);
        check("R10 resv_valid", {63'd0, resv_valid}, 64'd1);
        check("R10 resv_addr", resv_addr, 64'h8000_1000);

        // R11 plain cancel
        resv_cancel = 1;
        @(negedge clk);
        resv_cancel = 0;
        check("R11 cancel clears", {63'd0, resv_valid}, 64'd0);

        // R10 faulting reserved load sets nothing
        send(64'h8000_3000, 2'b11, 1'b0, 1'b1, 5'd4, DB, 1'b1, 5'd5, 1'b0);
        check("R10 no set", {63'd0, resv_valid}, 64'd0);

        // R11 cancel collides with a reservation set
        send(64'h8000_4000, 2'b11, 1'b0, 1'b1, 5'd6, DB, 1'b0, 5'd0, 1'b0);
        check("R9 resv before collision", {63'd0, resv_valid}, 64'd1);
        send(64'h8000_5000, 2'b11, 1'b0, 1'b1, 5'd6, DB, 1'b0, 5'd0, 1'b1);
        check("R11 collision wb_valid", {63'd0, wb_valid}, 64'd1);
        check("R11 collision resv_valid", {63'd0, resv_valid}, 64'd0);

        // R1 R2 R3 misalignment, combinational
        req_valid = 1;
        for (int a = 0; a < 8; a++) begin
            for (int w = 0; w < 4; w++) begin
                logic expm;
                req_addr = 64'h4000 + a; req_width = w[1:0]; plat_misaligned_ok = 0;
                case (w)
                    0: expm = 1'b0;
                    1: expm = (a % 2) != 0;
                    2: expm = (a % 4) != 0;
                    default: expm = a != 0;
                endcase
                #1;
                check($sformatf("%s a=%0d w=%0d", (w == 0) ? "R1" : "R2", a, w),
                      {63'd0, misaligned}, {63'd0, expm});
                plat_misaligned_ok = 1;
                #1;
                check("R3 platform enable", {63'd0, misaligned}, 64'd0);
            end
        end
        req_valid = 0;
        plat_misaligned_ok = 0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule